// File: doc/BRIEF.md
# Supervisory Watchdog with Startup Window

This block supervises a processor by watching a kick input. Either polarity of transition on the kick pin restarts a tick-based timeout. When the count runs out without a kick, the active-low fault output goes low. The timebase is a slow tick strobe supplied from outside, so every window is a count of ticks. An optional startup window, usually much longer, covers slow boot code after each reset event. That window ends at the first kick. From then on the normal timeout applies.

A mode bit chooses when the watchdog arms. In the dependent mode it waits for sequencing to finish and for the system reset to be released. In the independent mode it arms as soon as the enable input and the boot-complete input are both high. When the reset-output enable is set, an expiry drives a reset request low for a programmable number of ticks, and the fault output gives only a short pulse of fixed clock length. Once that reset request ends, the watchdog re-arms as it does after any reset event.

Top module: `wdog_supervisor`

## Requirements
- R1: After the asynchronous reset, `wdoN` and `rstReqN` are both high.
- R2: A rising edge and a falling edge on `kick` each count as a kick, clearing the tick count, after a two-flop synchroniser (acted on at the third clock edge).
- R3: Armed and past the startup window, if no kick arrives for `cfgTimeout` ticks with `cfgRstOutEn`=0, `wdoN` goes low on the clock edge of the expiring tick and stays low.
- R4: A kick while `wdoN` is low from a timeout drives `wdoN` high again and restarts the normal timeout.
- R5: With `cfgIndep`=0, the watchdog stays idle (no expiry) while `seqDone` is low or `sysRstN` is low, and it arms once both are high.
- R6: With `cfgIndep`=1, the watchdog arms with `enable` and `bootDone` high, regardless of `seqDone` and `sysRstN`.
- R7: With `cfgIndep`=0, a low `sysRstN` clears the count and drives `wdoN` high within two clocks.
- R8: While `enable` or `bootDone` is low, the block is held: `wdoN` and `rstReqN` are high from the next clock on.
- R9: With `cfgStartEn`=1, after arming no expiry occurs before `cfgStartup` ticks, and the first kick in that window starts the normal `cfgTimeout` timeout.
- R10: If the startup window runs out with no kick, this is handled as an expiry.
- R11: With `cfgRstOutEn`=1, an expiry drives `rstReqN` low for exactly `cfgRstLen` ticks and `wdoN` low for exactly `PULSE_CYC` clocks, both starting on the same edge.
- R12: When the watchdog-driven reset request ends, the watchdog re-arms and re-enters the startup window if `cfgStartEn`=1.
- R13: Taking `enable` low and then high again restarts the startup window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timebase strobe |
| kick | input | 1 | Asynchronous kick from the processor |
| enable | input | 1 | Watchdog enable; low holds the block |
| bootDone | input | 1 | Supply good and boot complete |
| seqDone | input | 1 | Power sequencing finished |
| sysRstN | input | 1 | System reset status, low while asserted |
| cfgIndep | input | 1 | 0 dependent arming, 1 independent arming |
| cfgStartEn | input | 1 | Startup window enable |
| cfgRstOutEn | input | 1 | Expiry drives the reset request |
| cfgTimeout | input | CNT_W | Normal timeout in ticks (at least 1) |
| cfgStartup | input | CNT_W | Startup window in ticks (at least 1) |
| cfgRstLen | input | CNT_W | Reset request length in ticks (at least 1) |
| wdoN | output | 1 | Active-low watchdog fault |
| rstReqN | output | 1 | Active-low reset request on expiry |

## Verification
The assertions assume that `tick` is a single-clock strobe and that the three count settings are never zero. They also assume that configuration changes only while the block is held or between windows, so that an expiry can always be traced back to a tick edge in an armed cycle. The bench produces `tick` as one clock in every four, from a divider running on the falling edge. It uses counts of at least 3, changes modes only while `enable` is low or between checks, and keeps `kick` low through reset so that the synchroniser sees no false edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_RUN, ST_EXPIRED, ST_RSTPULSE
  } wdState_e;

  typedef struct packed {
    logic cntClr;
    logic pulseStart;
    logic pulseKill;
  } wdStrobe_t;

  typedef struct packed {
    logic kickEdge;
    logic atTimeout;
    logic atStartup;
    logic atRstLen;
    logic pulseBusy;
  } wdFlag_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int PULSE_CYC   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] cfgTimeout,
  input  logic [CNT_W-1:0] cfgStartup,
  input  logic [CNT_W-1:0] cfgRstLen,
  input  wdStrobe_t        stb,
  output wdFlag_t          flags
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYC);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [CNT_W-1:0]       cnt;
  logic [PW-1:0]          pulseCnt;

  // kick synchroniser and previous-sample flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], kick};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  // shared tick counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cnt <= '0;
    else if (stb.cntClr)              cnt <= '0;
    else if (tick && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  // short fault pulse in reset-output mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pulseCnt <= '0;
    else if (stb.pulseKill)    pulseCnt <= '0;
    else if (stb.pulseStart)   pulseCnt <= PULSE_LOAD;
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
  end

  always_comb begin
    flags.kickEdge  = syncQ[SYNC_STAGES-1] ^ prevQ;
    flags.atTimeout = (cnt == cfgTimeout - 1'b1);
    flags.atStartup = (cnt == cfgStartup - 1'b1);
    flags.atRstLen  = (cnt == cfgRstLen - 1'b1);
    flags.pulseBusy = (pulseCnt != '0);
  end
endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      enable,
  input  logic      bootDone,
  input  logic      seqDone,
  input  logic      sysRstN,
  input  logic      cfgIndep,
  input  logic      cfgStartEn,
  input  logic      cfgRstOutEn,
  input  wdFlag_t   flags,
  output wdStrobe_t stb,
  output logic      wdoN,
  output logic      rstReqN
);
  wdState_e state, stateNxt;
  logic holdHard, holdSoft, expireGo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    expireGo = 1'b0;
    holdHard = !enable || !bootDone;
    holdSoft = !cfgIndep && (!seqDone || !sysRstN);
    case (state)
      ST_IDLE: begin
        if (!holdHard && !holdSoft) begin
          stateNxt   = cfgStartEn ? ST_START : ST_RUN;
          stb.cntClr = 1'b1;
        end
      end
      ST_START: begin
        if (holdHard || holdSoft) begin
          stateNxt      = ST_IDLE;
          stb.cntClr    = 1'b1;
          stb.pulseKill = 1'b1;
        end else if (flags.kickEdge) begin
          stateNxt   = ST_RUN;
          stb.cntClr = 1'b1;
        end else if (tick && flags.atStartup) begin
          expireGo = 1'b1;
        end
      end
      ST_RUN: begin
        if (holdHard || holdSoft) begin
          stateNxt      = ST_IDLE;
          stb.cntClr    = 1'b1;
          stb.pulseKill = 1'b1;
        end else if (flags.kickEdge) begin
          stb.cntClr = 1'b1;
        end else if (tick && flags.atTimeout) begin
          expireGo = 1'b1;
        end
      end
      ST_EXPIRED: begin
        if (holdHard || holdSoft) begin
          stateNxt      = ST_IDLE;
          stb.cntClr    = 1'b1;
          stb.pulseKill = 1'b1;
        end else if (flags.kickEdge) begin
          stateNxt   = ST_RUN;
          stb.cntClr = 1'b1;
        end
      end
      ST_RSTPULSE: begin
        if (holdHard) begin
          stateNxt      = ST_IDLE;
          stb.cntClr    = 1'b1;
          stb.pulseKill = 1'b1;
        end else if (tick && flags.atRstLen) begin
          stateNxt   = ST_IDLE;
          stb.cntClr = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase

    if (expireGo) begin
      stb.cntClr = 1'b1;
      if (cfgRstOutEn) begin
        stateNxt       = ST_RSTPULSE;
        stb.pulseStart = 1'b1;
      end else begin
        stateNxt = ST_EXPIRED;
      end
    end
  end

  assign wdoN    = !((state == ST_EXPIRED) || flags.pulseBusy);
  assign rstReqN = (state != ST_RSTPULSE);
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int PULSE_CYC   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             kick,
  input  logic             enable,
  input  logic             bootDone,
  input  logic             seqDone,
  input  logic             sysRstN,
  input  logic             cfgIndep,
  input  logic             cfgStartEn,
  input  logic             cfgRstOutEn,
  input  logic [CNT_W-1:0] cfgTimeout,
  input  logic [CNT_W-1:0] cfgStartup,
  input  logic [CNT_W-1:0] cfgRstLen,
  output logic             wdoN,
  output logic             rstReqN
);
  wdStrobe_t stb;
  wdFlag_t   flags;

  wdog_datapath #(
    .CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick),
    .cfgTimeout(cfgTimeout), .cfgStartup(cfgStartup), .cfgRstLen(cfgRstLen),
    .stb(stb), .flags(flags)
  );

  wdog_control u_ctl (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable),
    .bootDone(bootDone), .seqDone(seqDone), .sysRstN(sysRstN),
    .cfgIndep(cfgIndep), .cfgStartEn(cfgStartEn), .cfgRstOutEn(cfgRstOutEn),
    .flags(flags), .stb(stb), .wdoN(wdoN), .rstReqN(rstReqN)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic enable,
  input logic bootDone,
  input logic seqDone,
  input logic sysRstN,
  input logic cfgIndep,
  input logic wdoN,
  input logic rstReqN
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!enable || !bootDone) |=> (wdoN && rstReqN));

  assert_expiry_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdoN) |-> $past(tick));

  assert_expiry_armed_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdoN) |-> $past(enable && bootDone && (cfgIndep || (seqDone && sysRstN))));

  assert_rst_with_wdo_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstReqN) |-> !wdoN);

  assert_rst_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReqN) |-> ($past(tick) || $past(!enable || !bootDone)));
endmodule

bind wdog_supervisor wdog_checker u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .bootDone(bootDone),
  .seqDone(seqDone), .sysRstN(sysRstN), .cfgIndep(cfgIndep),
  .wdoN(wdoN), .rstReqN(rstReqN)
);

// File: tb/tb_wdog_supervisor.sv
module tb_wdog_supervisor;
  localparam int CW = 8;
  localparam int PC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic kick = 1'b0;
  logic enable = 1'b1, bootDone = 1'b1, seqDone = 1'b1, sysRstN = 1'b1;
  logic cfgIndep = 1'b1, cfgStartEn = 1'b0, cfgRstOutEn = 1'b0;
  logic [CW-1:0] cfgTimeout = 8'd4, cfgStartup = 8'd12, cfgRstLen = 8'd5;
  logic wdoN, rstReqN;

  int errCnt = 0;
  int chkCnt = 0;

  wdog_supervisor #(.CNT_W(CW), .PULSE_CYC(PC)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick), .enable(enable),
    .bootDone(bootDone), .seqDone(seqDone), .sysRstN(sysRstN),
    .cfgIndep(cfgIndep), .cfgStartEn(cfgStartEn), .cfgRstOutEn(cfgRstOutEn),
    .cfgTimeout(cfgTimeout), .cfgStartup(cfgStartup), .cfgRstLen(cfgRstLen),
    .wdoN(wdoN), .rstReqN(rstReqN)
  );

  always #5 clk = ~clk;

  // tick strobe: one clock in four
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div  = (div + 1) % 4;
      tick = (div == 0);
    end
  end

  typedef struct packed {
    logic [7:0] tmo;
    logic [7:0] nTicks;
    logic       expHigh;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'd4, 8'd2, 1'b1}, '{8'd4, 8'd5, 1'b0},
    '{8'd6, 8'd4, 1'b1}, '{8'd6, 8'd7, 1'b0},
    '{8'd3, 8'd1, 1'b1}, '{8'd3, 8'd4, 1'b0},
    '{8'd8, 8'd6, 1'b1}, '{8'd8, 8'd9, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic doKick();
    @(negedge clk);
    kick = ~kick;
    repeat (4) @(negedge clk);
  endtask

  task automatic cycleEnable();
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chkCnt++;
    errCnt++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finishRun();
  end

  initial begin
    int lowW;
    int lowR;
    int guard;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 wdoN in reset", wdoN, 1);
    check("R1 rstReqN in reset", rstReqN, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 wdoN after reset", wdoN, 1);
    check("R1 rstReqN after reset", rstReqN, 1);

    // table: R2 (alternating edges), R3 expiry, R4 recovery
    for (int i = 0; i < 8; i++) begin
      cfgTimeout = VEC[i].tmo;
      doKick();
      check($sformatf("R4 high after kick row %0d", i), wdoN, 1);
      waitTicks(int'(VEC[i].nTicks));
      check($sformatf("R2/R3 row %0d", i), wdoN, int'(VEC[i].expHigh));
    end

    // R5 dependent mode idles until sequencing done and reset released
    cfgTimeout = 8'd3;
    @(negedge clk);
    cfgIndep = 1'b0;
    seqDone  = 1'b0;
    waitTicks(10);
    check("R5 idle while seqDone low", wdoN, 1);
    seqDone = 1'b1;
    sysRstN = 1'b0;
    waitTicks(10);
    check("R5 idle while sysRstN low", wdoN, 1);
    sysRstN = 1'b1;
    waitTicks(5);
    check("R5 armed expiry", wdoN, 0);
    // R7 system reset clears fault
    sysRstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 wdoN cleared by sysRstN", wdoN, 1);
    waitTicks(6);
    check("R7 held while sysRstN low", wdoN, 1);

    // R6 independent mode ignores sequencing and system reset
    cfgIndep = 1'b1;
    seqDone  = 1'b0;
    cycleEnable();
    waitTicks(5);
    check("R6 independent expiry", wdoN, 0);
    seqDone = 1'b1;
    sysRstN = 1'b1;

    // R8 enable low holds
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 wdoN high when disabled", wdoN, 1);
    waitTicks(8);
    check("R8 still high when disabled", wdoN, 1);
    check("R8 rstReqN high when disabled", rstReqN, 1);

    // R9 / R13 startup window restarted by enable cycle
    cfgStartEn = 1'b1;
    cfgStartup = 8'd12;
    cycleEnable();
    waitTicks(8);
    check("R9/R13 no expiry inside startup window", wdoN, 1);
    doKick();
    waitTicks(1);
    check("R9 normal timeout after first kick, early", wdoN, 1);
    waitTicks(3);
    check("R9 normal timeout after first kick, expired", wdoN, 0);

    // R10 startup window expiry without kick
    cycleEnable();
    waitTicks(10);
    check("R10 before startup end", wdoN, 1);
    waitTicks(3);
    check("R10 startup expiry", wdoN, 0);

    // R11 reset-output mode
    @(negedge clk);
    enable      = 1'b0;
    cfgStartEn  = 1'b0;
    cfgRstOutEn = 1'b1;
    cfgRstLen   = 8'd5;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    guard = 0;
    while (rstReqN && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    check("R11 reset request seen", rstReqN, 0);
    check("R11 wdoN low at reset start", wdoN, 0);
    cfgStartEn = 1'b1;
    cfgStartup = 8'd10;
    lowW = 0;
    lowR = 0;
    while (!rstReqN && lowR < 400) begin
      if (!wdoN) lowW++;
      lowR++;
      @(negedge clk);
    end
    check("R11 wdoN pulse clocks", lowW, PC);
    check("R11 rstReqN low clocks (5 ticks of 4)", lowR, 20);

    // R12 re-arm into startup window after watchdog reset
    waitTicks(6);
    check("R12 no expiry early in new startup window", rstReqN, 1);
    check("R12 wdoN high in new startup window", wdoN, 1);
    waitTicks(6);
    check("R12 startup expiry drives reset again", rstReqN, 0);

    finishRun();
  end
endmodule